// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received packet bytes and places them in memory buffers that software provides through a ring of two-word descriptors. Software fills a descriptor with a buffer pointer and sets its ownership bit, then moves a tail index forward to hand it over. The engine fetches a descriptor only when its own current index differs from that tail. It fills the buffer until the buffer is full or the packet ends. It then overwrites the descriptor in write-back form, so that software never sees a used descriptor that still looks unused.

Incoming bytes pass through a packet FIFO that releases a packet to the engine only once the whole packet has arrived. When the FIFO cannot hold a packet, the input is never stalled. The whole packet is discarded and counted. When the engine reaches a descriptor that software still owns, it suspends, raises a buffer-unavailable flag, and waits for the next tail write.

Top module: `rxd_dma_top`

## Requirements
- R1: A descriptor is fetched only when the tail index differs from the current index and at least one complete packet byte is buffered. While the two indexes are equal, the engine issues no memory request.
- R2: Descriptor word 1 bit 31 is ownership, where 1 means the engine may use the descriptor. When a fetched descriptor has bit 31 at 0, the engine raises `rbu`, keeps the current index, writes nothing to that descriptor, and makes no memory request while `rbu` is high.
- R3: A pulse on `tail_wr` loads `tail_idx` and clears `rbu`. The engine then refetches the descriptor it suspended on.
- R4: Descriptor word 0 holds a byte buffer pointer. Bytes are stored at consecutive byte addresses starting there. The buffer capacity is `cfg_buf_size` minus pointer bits [1:0]. Filling stops at the end of the packet or when the capacity is reached, and the rest of the packet continues in the next descriptor.
- R5: Write-back format: word 0 holds the number of bytes stored in this buffer. In word 1, bit 31 is 0, bit 30 is 1, bit 29 is the first flag, bit 28 is the last flag, and bits [15:0] hold the total packet length on the last descriptor and 0 on any other descriptor.
- R6: The first flag is set exactly on the descriptor that receives the first byte of a packet.
- R7: Descriptor i is located at `cfg_ring_base + 8*i`. The current index steps from `cfg_ring_len-1` back to 0.
- R8: If a packet byte arrives while the FIFO is full, every byte of that packet is discarded and `drop_cnt` increments by exactly one. Packets already complete in the FIFO are not affected.
- R9: After reset, `rbu` is 0, `cur_idx` is 0, `drop_cnt` is 0, and no memory request is made.
- R10: When a packet needs another descriptor and the tail equals the current index, the engine waits with the remaining bytes held. After the tail advances, it continues the same packet without setting the first flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 |
| cfg_ring_len | input | IDX_W | Number of descriptors in the ring |
| cfg_buf_size | input | 16 | Buffer size in bytes |
| tail_wr | input | 1 | Tail index write strobe |
| tail_idx | input | IDX_W | New tail index |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a packet |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| rbu | output | 1 | Receive buffer unavailable, engine suspended |
| cur_idx | output | IDX_W | Current descriptor index |
| drop_cnt | output | DROP_W | Count of discarded packets |

## Verification
The assertions check the following on every cycle:
- the engine stays off the memory port while suspended or while the tail equals the current index;
- a buffer write never goes beyond the computed capacity;
- the FIFO never holds more than its depth, and the engine pops only bytes of complete packets;
- the drop counter moves by at most one per cycle;
- the current index stays inside the ring.

Only the bench scenarios can show the following:
- the exact write-back words and the byte placement, including a nonzero pointer offset;
- a packet split across descriptors;
- resumption after a suspend and after a mid-packet stall;
- that dropped packets leave no trace in memory.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_CHK, S_XFER, S_WB0, S_WB1
  } eng_state_t;

  localparam int OWN_BIT   = 31;
  localparam int WB_BIT    = 30;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT  = 28;
endpackage

// File: rtl/rxd_pkt_fifo.sv
module rxd_pkt_fifo #(
  parameter int AW     = 4,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              pop,
  output logic              avail,
  output logic [7:0]        rd_data,
  output logic              rd_last,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int DEPTH = 1 << AW;

  logic [8:0]  ram [DEPTH];
  logic [AW:0] wr_ptr, cm_ptr, rd_ptr, used;
  logic        dropping, full, do_wr;

  assign used  = wr_ptr - rd_ptr;
  assign full  = (used == (AW+1)'(DEPTH));
  assign do_wr = in_valid && !dropping && !full;
  assign avail = (cm_ptr != rd_ptr);
  assign {rd_last, rd_data} = ram[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) ram[wr_ptr[AW-1:0]] <= {in_last, in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      cm_ptr   <= '0;
      rd_ptr   <= '0;
      dropping <= 1'b0;
      drop_cnt <= '0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (in_valid) begin
        if (dropping) begin
          if (in_last) dropping <= 1'b0;
        end else if (full) begin
          wr_ptr   <= cm_ptr;
          dropping <= !in_last;
          drop_cnt <= drop_cnt + 1'b1;
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
          if (in_last) cm_ptr <= wr_ptr + 1'b1;
        end
      end
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    used <= (AW+1)'(DEPTH)); // R8
  AST_POP_COMMITTED: assert property (@(posedge clk) disable iff (rst)
    pop |-> avail); // R8
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1)); // R8
endmodule

// File: rtl/rxd_ring_idx.sv
module rxd_ring_idx #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      cfg_ring_base,
  input  logic [IDX_W-1:0] cfg_ring_len,
  input  logic             tail_wr,
  input  logic [IDX_W-1:0] tail_idx,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_idx,
  output logic [31:0]      desc_addr,
  output logic             fetch_ok
);
  logic [IDX_W-1:0] tail_q;

  assign desc_addr = cfg_ring_base + {{(29-IDX_W){1'b0}}, cur_idx, 3'b000};
  assign fetch_ok  = (tail_q != cur_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
      tail_q  <= '0;
    end else begin
      if (tail_wr) tail_q <= tail_idx;
      if (advance) cur_idx <= (cur_idx == cfg_ring_len - 1'b1) ? '0 : cur_idx + 1'b1;
    end
  end

  AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (rst)
    (cfg_ring_len != '0) |-> (cur_idx < cfg_ring_len)); // R7
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cfg_buf_size,
  input  logic [31:0] desc_addr,
  input  logic        fetch_ok,
  input  logic        tail_wr,
  input  logic        fifo_avail,
  input  logic [7:0]  fifo_data,
  input  logic        fifo_last,
  output logic        fifo_pop,
  output logic        advance,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        rbu
);
  eng_state_t  st;
  logic [31:0] buf_ptr, wa;
  logic [15:0] cnt, cap, pkt_len;
  logic        first_q, last_q;

  assign wa = buf_ptr + {16'b0, cnt};

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_be    = 4'b0000;
    mem_wdata = '0;
    fifo_pop  = 1'b0;
    advance   = 1'b0;
    case (st)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + 32'd4;
      end
      S_XFER: if (fifo_avail) begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {wa[31:2], 2'b00};
        mem_be    = 4'b0001 << wa[1:0];
        mem_wdata = {4{fifo_data}};
        fifo_pop  = 1'b1;
      end
      S_WB0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = {16'b0, cnt};
      end
      S_WB1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_addr  = desc_addr + 32'd4;
        mem_wdata = '0;
        mem_wdata[WB_BIT]    = 1'b1;
        mem_wdata[FIRST_BIT] = first_q;
        mem_wdata[LAST_BIT]  = last_q;
        mem_wdata[15:0]      = last_q ? pkt_len : 16'd0;
        advance   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      buf_ptr <= '0;
      cnt     <= '0;
      cap     <= '0;
      pkt_len <= '0;
      first_q <= 1'b1;
      last_q  <= 1'b0;
      rbu     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!rbu && fetch_ok && fifo_avail) st <= S_RD0;
        S_RD0:  st <= S_RD1;
        S_RD1: begin
          buf_ptr <= mem_rdata;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (mem_rdata[OWN_BIT]) begin
            cnt    <= '0;
            cap    <= cfg_buf_size - {14'b0, buf_ptr[1:0]};
            last_q <= 1'b0;
            st     <= S_XFER;
          end else begin
            rbu <= 1'b1;
            st  <= S_IDLE;
          end
        end
        S_XFER: if (fifo_avail) begin
          cnt     <= cnt + 16'd1;
          pkt_len <= pkt_len + 16'd1;
          if (fifo_last) begin
            last_q <= 1'b1;
            st     <= S_WB0;
          end else if (cnt + 16'd1 == cap) begin
            st <= S_WB0;
          end
        end
        S_WB0: st <= S_WB1;
        S_WB1: begin
          first_q <= last_q;
          if (last_q) pkt_len <= '0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (tail_wr) rbu <= 1'b0;
    end
  end

  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !fetch_ok) |=> !mem_req); // R1
  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (rst)
    rbu |-> !mem_req); // R2
  AST_FILL_WITHIN_CAP: assert property (@(posedge clk) disable iff (rst)
    (st == S_XFER) |-> (cnt < cap)); // R4
endmodule

// File: rtl/rxd_dma_top.sv
module rxd_dma_top #(
  parameter int IDX_W   = 4,
  parameter int FIFO_AW = 4,
  parameter int DROP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_ring_base,
  input  logic [IDX_W-1:0]  cfg_ring_len,
  input  logic [15:0]       cfg_buf_size,
  input  logic              tail_wr,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              rbu,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [DROP_W-1:0] drop_cnt
);
  logic        fifo_avail, fifo_last, fifo_pop, advance, fetch_ok;
  logic [7:0]  fifo_data;
  logic [31:0] desc_addr;

  rxd_pkt_fifo #(.AW(FIFO_AW), .DROP_W(DROP_W)) u_fifo (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .pop(fifo_pop), .avail(fifo_avail), .rd_data(fifo_data), .rd_last(fifo_last),
    .drop_cnt(drop_cnt)
  );

  rxd_ring_idx #(.IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst(rst),
    .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len),
    .tail_wr(tail_wr), .tail_idx(tail_idx), .advance(advance),
    .cur_idx(cur_idx), .desc_addr(desc_addr), .fetch_ok(fetch_ok)
  );

  rxd_engine u_eng (
    .clk(clk), .rst(rst),
    .cfg_buf_size(cfg_buf_size), .desc_addr(desc_addr), .fetch_ok(fetch_ok),
    .tail_wr(tail_wr),
    .fifo_avail(fifo_avail), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_pop(fifo_pop), .advance(advance),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rbu(rbu)
  );
endmodule

// File: tb/rxd_dma_top_bench.sv
module rxd_dma_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int DROP_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] cfg_ring_base = 32'h0;
  logic [IDX_W-1:0] cfg_ring_len = 4'd4;
  logic [15:0] cfg_buf_size = 16'd8;
  logic tail_wr = 1'b0;
  logic [IDX_W-1:0] tail_idx = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic mem_req, mem_we, rbu;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [IDX_W-1:0] cur_idx;
  logic [DROP_W-1:0] drop_cnt;

  logic [31:0] bmem [0:255];
  logic sw_we = 1'b0;
  logic [31:0] sw_addr = '0, sw_data = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxd_dma_top u_rxd_dma_top (
    .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len),
    .cfg_buf_size(cfg_buf_size), .tail_wr(tail_wr), .tail_idx(tail_idx),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rbu(rbu), .cur_idx(cur_idx),
    .drop_cnt(drop_cnt)
  );

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = '0;
  end

  always @(posedge clk) begin
    if (sw_we) bmem[sw_addr[9:2]] <= sw_data;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= bmem[mem_addr[9:2]];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] getb(input int a);
    return bmem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); sw_we = 1'b1; sw_addr = a; sw_data = d;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic give_tail(input logic [IDX_W-1:0] t);
    @(negedge clk); tail_wr = 1'b1; tail_idx = t;
    @(negedge clk); tail_wr = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = seed + 8'(i); in_last = (i == n - 1);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic check_bytes(input string req, input int addr, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) check(req, 32'(getb(addr + i)), 32'(seed + 8'(i)));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 rbu", 32'(rbu), 0);
    check("R9 cur_idx", 32'(cur_idx), 0);
    check("R9 drop_cnt", 32'(drop_cnt), 0);
    check("R9 mem_req", 32'(mem_req), 0);

    // Single-buffer packet in descriptor 0
    sw_write(32'h000, 32'h100);
    sw_write(32'h004, 32'h8000_0000);
    give_tail(4'd1);
    send_pkt(5, 8'h10);
    settle();
    check("R5 d0 count", bmem[0], 32'd5);
    check("R5 R6 d0 wb", bmem[1], 32'h7000_0005);
    check_bytes("R4 d0 data", 32'h100, 5, 8'h10);
    check("R4 stop at end", 32'(getb(32'h105)), 0);
    check("R7 cur after d0", 32'(cur_idx), 1);

    // Multi-buffer packet with a pointer offset
    sw_write(32'h008, 32'h121);
    sw_write(32'h00C, 32'h8000_0000);
    sw_write(32'h010, 32'h140);
    sw_write(32'h014, 32'h8000_0000);
    give_tail(4'd3);
    send_pkt(12, 8'h20);
    settle();
    check("R4 d1 count offset", bmem[2], 32'd7);
    check("R6 d1 first only", bmem[3], 32'h6000_0000);
    check_bytes("R4 d1 data", 32'h121, 7, 8'h20);
    check("R4 offset byte", 32'(getb(32'h120)), 0);
    check("R5 d2 count", bmem[4], 32'd5);
    check("R5 d2 last len", bmem[5], 32'h5000_000C);
    check_bytes("R4 d2 data", 32'h140, 5, 8'h27);
    check("R7 cur after d2", 32'(cur_idx), 3);

    // Software-owned descriptor: suspend
    sw_write(32'h018, 32'h160);
    sw_write(32'h01C, 32'h0000_0000);
    give_tail(4'd0);
    send_pkt(3, 8'h40);
    settle();
    check("R2 rbu set", 32'(rbu), 1);
    check("R2 cur held", 32'(cur_idx), 3);
    check("R2 d3 untouched", bmem[7], 32'h0);
    check("R2 no data", 32'(getb(32'h160)), 0);

    // Fill FIFO while suspended: 3 + 10 fit, next two packets drop
    send_pkt(10, 8'h50);
    send_pkt(6, 8'h70);
    check("R8 drop one", 32'(drop_cnt), 1);
    send_pkt(6, 8'h80);
    settle();
    check("R8 drop two", 32'(drop_cnt), 2);
    check("R2 still suspended", 32'(rbu), 1);

    // Hand descriptors back and resume
    sw_write(32'h01C, 32'h8000_0000);
    sw_write(32'h000, 32'h180);
    sw_write(32'h004, 32'h8000_0000);
    give_tail(4'd1);
    check("R3 rbu cleared", 32'(rbu), 0);
    settle();
    check("R3 d3 count", bmem[6], 32'd3);
    check("R3 d3 wb", bmem[7], 32'h7000_0003);
    check_bytes("R3 d3 data", 32'h160, 3, 8'h40);
    check("R7 wrap d0 count", bmem[0], 32'd8);
    check("R6 R7 d0 first", bmem[1], 32'h6000_0000);
    check_bytes("R7 d0 data", 32'h180, 8, 8'h50);
    check("R10 stalled cur", 32'(cur_idx), 1);
    check("R1 no fetch at tail", 32'(rbu), 0);
    check("R1 d1 unchanged", bmem[3], 32'h6000_0000);

    // Continue mid-packet after tail advance
    sw_write(32'h008, 32'h1A0);
    sw_write(32'h00C, 32'h8000_0000);
    give_tail(4'd2);
    settle();
    check("R10 d1 count", bmem[2], 32'd2);
    check("R10 d1 last no first", bmem[3], 32'h5000_000A);
    check_bytes("R10 d1 data", 32'h1A0, 2, 8'h58);
    check("R8 dropped not stored", 32'(getb(32'h1A2)), 0);
    check("R8 d2 untouched", bmem[5], 32'h5000_000C);
    check("R1 cur at tail", 32'(cur_idx), 2);
    check("R8 final drops", 32'(drop_cnt), 2);
    summary();
  end
endmodule